// File: doc/BRIEF.md
# Test-Port Configuration Programming Controller

This block lets a board tester or an on-board processor reprogram a small configuration store through nothing more than a standard four-wire test access port. The port is clocked by TCK and steered by TMS. A 4-bit instruction register picks one of several commands. One command unlocks the store. Another clears all of it. A third writes one row from a row-wide serial shift register. A fourth reads a row back so it can be shifted out on TDO and compared with the intended image. A private instruction loads the row address. No programming voltage input or other side channel exists.

The store holds 16 rows of 32 bits in ordinary registers. It stands in for a nonvolatile array. A power-on reset brings it to the erased value, in which every bit is 1. A return of the port to its reset state does not touch the store. The clear, write and read-back commands do nothing until an unlock command has completed. The unlocked condition then lasts through any number of later commands, until the port goes back to Test-Logic-Reset.

Top module: `isp_jtag_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the port sits in Test-Logic-Reset with the store locked, and every row of the store reads 32'hFFFF_FFFF.
- R2: Five consecutive TCK rising edges with TMS high bring the port to Test-Logic-Reset from any state. Entering that state locks the store again and leaves the contents of every row unchanged.
- R3: Instruction 4'b1001 (unlock) selects the 32-bit ISP shift register. It unlocks the store when the port passes Update-DR. The store stays unlocked across all later instructions until the port reaches Test-Logic-Reset.
- R4: With the store unlocked, instruction 4'b1010 (clear) sets every bit of every row to 1 on each TCK edge that the port spends in Run-Test/Idle.
- R5: With the store unlocked, instruction 4'b1011 (write) copies the 32-bit ISP shift register into the addressed row when the port passes Update-DR.
- R6: With the store unlocked, instruction 4'b1100 (read-back) loads the addressed row into the ISP shift register in Capture-DR. Shift-DR then presents that row on TDO, bit 0 first, while TDI fills the register from bit 31 downwards.
- R7: While the store is locked, clear and write leave the store unchanged, and read-back captures 32'h0000_0000.
- R8: Instruction 4'b0100 selects a 4-bit address register, shifted bit 0 first. It captures the current row address and takes the new one at Update-DR. The address picks exactly one of the 16 rows.
- R9: Any instruction code not listed in R3 to R8 selects a 1-bit bypass register that captures 0. Through it, TDO repeats TDI one TCK later. It leaves the store and the lock state unchanged.
- R10: Capture-IR loads 4'b0001 into the instruction shift register, and Shift-IR presents it on TDO bit 0 first. Instructions are shifted in bit 0 first and take effect at Update-IR. Test-Logic-Reset selects the bypass instruction.
- R11: TDO is 0 in every port state other than Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high power-on reset |
| tms | input | 1 | Test mode select, steers the port state machine |
| tdi | input | 1 | Serial data in, shifted into the selected register |
| tdo | output | 1 | Serial data out, bit 0 of the selected register while shifting |

## Verification
The hardest case to reach from the pins is an unlock that has been cancelled while the rows it protected keep their data. The stimulus first unlocks the store and writes two rows. It then stops part way through a data shift and holds TMS high for five edges. After that it attempts a read-back and a clear while locked, and expects zeros from the read-back. Finally it unlocks again and expects the earlier row data unchanged. A second sequence loads an unknown instruction and shifts data through the bypass bit. It then checks that a read-back without a new unlock still succeeds, which shows that the lock state survived the bypass traffic.

// File: rtl/isp_pkg.sv
package isp_pkg;

    localparam int IR_W     = 4;
    localparam int ROWS     = 16;
    localparam int ROW_W    = 32;
    localparam int ADDR_W   = $clog2(ROWS);

    localparam logic [IR_W-1:0] CODE_ADDR    = 4'b0100;
    localparam logic [IR_W-1:0] CODE_UNLOCK  = 4'b1001;
    localparam logic [IR_W-1:0] CODE_CLEAR   = 4'b1010;
    localparam logic [IR_W-1:0] CODE_WRITE   = 4'b1011;
    localparam logic [IR_W-1:0] CODE_READ    = 4'b1100;
    localparam logic [IR_W-1:0] CODE_BYPASS  = 4'b1111;
    localparam logic [IR_W-1:0] IR_CAPTURE   = 4'b0001;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        DR_BYPASS,
        DR_ADDR,
        DR_ISP
    } dr_sel_e;

    typedef struct packed {
        logic tlr;
        logic rti;
        logic cap_dr;
        logic shf_dr;
        logic upd_dr;
        logic cap_ir;
        logic shf_ir;
        logic upd_ir;
    } tap_ctl_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            ST_TLR:    n = m ? ST_TLR    : ST_RTI;
            ST_RTI:    n = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = m ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: n = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: n = m ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = m ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: n = m ? ST_SEL_DR : ST_RTI;
            default:   n = ST_TLR;
        endcase
        return n;
    endfunction

    function automatic dr_sel_e decode_dr(input logic [IR_W-1:0] code);
        dr_sel_e d;
        case (code)
            CODE_ADDR:                                       d = DR_ADDR;
            CODE_UNLOCK, CODE_CLEAR, CODE_WRITE, CODE_READ:  d = DR_ISP;
            default:                                         d = DR_BYPASS;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/isp_tap_fsm.sv
module isp_tap_fsm
    import isp_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_ctl_t   ctl
);

    tap_state_e state;

    always_ff @(posedge tck) begin
        if (rst) state <= ST_TLR;
        else     state <= tap_next(state, tms);
    end

    always_comb begin
        ctl        = '0;
        ctl.tlr    = (state == ST_TLR);
        ctl.rti    = (state == ST_RTI);
        ctl.cap_dr = (state == ST_CAP_DR);
        ctl.shf_dr = (state == ST_SHF_DR);
        ctl.upd_dr = (state == ST_UPD_DR);
        ctl.cap_ir = (state == ST_CAP_IR);
        ctl.shf_ir = (state == ST_SHF_IR);
        ctl.upd_ir = (state == ST_UPD_IR);
    end

    // R2: five high TMS edges always end in Test-Logic-Reset
    a_r2_five_high_reset: assert property (@(posedge tck) disable iff (rst)
        ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
        |-> (state == ST_TLR));

    // R1/R2: Test-Logic-Reset is held while TMS stays high
    a_r2_tlr_hold: assert property (@(posedge tck) disable iff (rst)
        (state == ST_TLR && tms) |=> (state == ST_TLR));

endmodule

// File: rtl/isp_cfg_array.sv
module isp_cfg_array
    import isp_pkg::*;
#(
    parameter int N_ROWS  = ROWS,
    parameter int WIDTH   = ROW_W,
    localparam int AW     = $clog2(N_ROWS)
)(
    input  logic             tck,
    input  logic             rst,
    input  logic             erase_en,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0]  rows [N_ROWS];
    logic [N_ROWS-1:0] row_hit;

    for (genvar r = 0; r < N_ROWS; r++) begin : g_hit
        assign row_hit[r] = wr_en && (addr == AW'(r));
    end

    always_ff @(posedge tck) begin
        for (int r = 0; r < N_ROWS; r++) begin
            if (rst || erase_en)  rows[r] <= '1;
            else if (row_hit[r])  rows[r] <= wdata;
        end
    end

    assign rdata = rows[addr];

    // R4: after a clear every row reads as all ones
    a_r4_clear_all_ones: assert property (@(posedge tck) disable iff (rst)
        $past(erase_en) |-> (rdata == '1));

    // R5: a write lands in the addressed row
    a_r5_write_lands: assert property (@(posedge tck) disable iff (rst)
        ($past(wr_en) && !$past(erase_en) && addr == $past(addr)) |-> (rdata == $past(wdata)));

    // R8: at most one row is selected for writing
    a_r8_one_row: assert property (@(posedge tck) disable iff (rst)
        $onehot0(row_hit));

endmodule

// File: rtl/isp_reg_chain.sv
module isp_reg_chain
    import isp_pkg::*;
#(
    parameter int WIDTH   = ROW_W,
    parameter int AW      = ADDR_W
)(
    input  logic             tck,
    input  logic             rst,
    input  tap_ctl_t         ctl,
    input  logic             tdi,
    input  logic [WIDTH-1:0] rdata,
    output logic [AW-1:0]    row_addr,
    output logic [WIDTH-1:0] wdata,
    output logic             wr_en,
    output logic             erase_en,
    output logic             tdo
);

    logic [IR_W-1:0]  ir;
    logic [IR_W-1:0]  ir_sr;
    logic [AW-1:0]    addr_sr;
    logic [WIDTH-1:0] isp_sr;
    logic             byp;
    logic             unlocked;
    dr_sel_e          sel;

    assign sel = decode_dr(ir);

    always_ff @(posedge tck) begin
        if (rst) begin
            ir       <= CODE_BYPASS;
            ir_sr    <= '0;
            row_addr <= '0;
            addr_sr  <= '0;
            isp_sr   <= '0;
            byp      <= 1'b0;
            unlocked <= 1'b0;
        end else begin
            if (ctl.tlr) begin
                ir       <= CODE_BYPASS;
                unlocked <= 1'b0;
            end
            if (ctl.cap_ir) ir_sr <= IR_CAPTURE;
            if (ctl.shf_ir) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
            if (ctl.upd_ir) ir    <= ir_sr;

            if (ctl.cap_dr) begin
                byp     <= 1'b0;
                addr_sr <= row_addr;
                if (ir == CODE_READ) isp_sr <= unlocked ? rdata : '0;
            end
            if (ctl.shf_dr) begin
                case (sel)
                    DR_ADDR:  addr_sr <= {tdi, addr_sr[AW-1:1]};
                    DR_ISP:   isp_sr  <= {tdi, isp_sr[WIDTH-1:1]};
                    default:  byp     <= tdi;
                endcase
            end
            if (ctl.upd_dr) begin
                if (ir == CODE_ADDR)   row_addr <= addr_sr;
                if (ir == CODE_UNLOCK) unlocked <= 1'b1;
            end
        end
    end

    assign wdata    = isp_sr;
    assign wr_en    = ctl.upd_dr && (ir == CODE_WRITE) && unlocked;
    assign erase_en = ctl.rti && (ir == CODE_CLEAR) && unlocked;

    always_comb begin
        tdo = 1'b0;
        if (ctl.shf_ir) begin
            tdo = ir_sr[0];
        end else if (ctl.shf_dr) begin
            case (sel)
                DR_ADDR:  tdo = addr_sr[0];
                DR_ISP:   tdo = isp_sr[0];
                default:  tdo = byp;
            endcase
        end
    end

    // R3: unlocked state lasts until Test-Logic-Reset
    a_r3_unlock_persists: assert property (@(posedge tck) disable iff (rst)
        (unlocked && !ctl.tlr) |=> unlocked);

    // R2: Test-Logic-Reset locks the store
    a_r2_tlr_locks: assert property (@(posedge tck) disable iff (rst)
        ctl.tlr |=> !unlocked);

    // R6: read-back capture holds the addressed row
    a_r6_read_capture: assert property (@(posedge tck) disable iff (rst)
        $past(ctl.cap_dr && ir == CODE_READ && unlocked) |-> (isp_sr == $past(rdata)));

    // R8: address update takes the shifted value
    a_r8_addr_update: assert property (@(posedge tck) disable iff (rst)
        $past(ctl.upd_dr && ir == CODE_ADDR) |-> (row_addr == $past(addr_sr)));

endmodule

// File: rtl/isp_jtag_ctrl.sv
module isp_jtag_ctrl
    import isp_pkg::*;
#(
    parameter int N_ROWS  = ROWS,
    parameter int WIDTH   = ROW_W,
    localparam int AW     = $clog2(N_ROWS)
)(
    input  logic tck,
    input  logic rst,
    input  logic tms,
    input  logic tdi,
    output logic tdo
);

    tap_ctl_t         ctl;
    logic [AW-1:0]    row_addr;
    logic [WIDTH-1:0] wdata;
    logic [WIDTH-1:0] rdata;
    logic             wr_en;
    logic             erase_en;

    isp_tap_fsm u_tap (
        .tck (tck),
        .rst (rst),
        .tms (tms),
        .ctl (ctl)
    );

    isp_reg_chain #(
        .WIDTH (WIDTH),
        .AW    (AW)
    ) u_chain (
        .tck      (tck),
        .rst      (rst),
        .ctl      (ctl),
        .tdi      (tdi),
        .rdata    (rdata),
        .row_addr (row_addr),
        .wdata    (wdata),
        .wr_en    (wr_en),
        .erase_en (erase_en),
        .tdo      (tdo)
    );

    isp_cfg_array #(
        .N_ROWS (N_ROWS),
        .WIDTH  (WIDTH)
    ) u_array (
        .tck      (tck),
        .rst      (rst),
        .erase_en (erase_en),
        .wr_en    (wr_en),
        .addr     (row_addr),
        .wdata    (wdata),
        .rdata    (rdata)
    );

    // R11: TDO quiet outside the shift states
    a_r11_tdo_quiet: assert property (@(posedge tck) disable iff (rst)
        !(ctl.shf_dr || ctl.shf_ir) |-> (tdo == 1'b0));

    // R7: the store changes only on a clear or a write
    a_r7_no_stray_change: assert property (@(posedge tck) disable iff (rst)
        (!$past(wr_en) && !$past(erase_en) && $stable(row_addr)) |-> $stable(rdata));

endmodule

// File: tb/isp_jtag_ctrl_tb.sv
module isp_jtag_ctrl_tb;

    logic tck = 1'b0;
    logic rst = 1'b1;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic tdo;

    int checks = 0;
    int errors = 0;

    localparam logic [3:0] C_ADDR   = 4'b0100;
    localparam logic [3:0] C_UNLOCK = 4'b1001;
    localparam logic [3:0] C_CLEAR  = 4'b1010;
    localparam logic [3:0] C_WRITE  = 4'b1011;
    localparam logic [3:0] C_READ   = 4'b1100;
    localparam logic [3:0] C_ODD    = 4'b0110;

    always #5 tck = ~tck;

    isp_jtag_ctrl u_dut (
        .tck (tck),
        .rst (rst),
        .tms (tms),
        .tdi (tdi),
        .tdo (tdo)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o);
        @(negedge tck);
        tms = m;
        tdi = d;
        #1 o = tdo;
        @(posedge tck);
    endtask

    task automatic idle(input int n);
        logic o;
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, o);
    endtask

    task automatic shift_ir(input logic [3:0] code, output logic [3:0] cap);
        logic o;
        step(1'b1, 1'b0, o);
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        for (int i = 0; i < 4; i++) step(i == 3, code[i], cap[i]);
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
    endtask

    task automatic load_ir(input logic [3:0] code);
        logic [3:0] c;
        shift_ir(code, c);
    endtask

    task automatic shift_dr(input logic [31:0] din, input int n, output logic [31:0] dout);
        logic o;
        dout = '0;
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        for (int i = 0; i < n; i++) step(i == n - 1, din[i], dout[i]);
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
    endtask

    task automatic set_addr(input logic [3:0] row, output logic [3:0] prev);
        logic [31:0] d;
        load_ir(C_ADDR);
        shift_dr({28'd0, row}, 4, d);
        prev = d[3:0];
    endtask

    task automatic write_row(input logic [3:0] row, input logic [31:0] data);
        logic [3:0]  p;
        logic [31:0] d;
        set_addr(row, p);
        load_ir(C_WRITE);
        shift_dr(data, 32, d);
    endtask

    task automatic read_row(input logic [3:0] row, output logic [31:0] data);
        logic [3:0] p;
        set_addr(row, p);
        load_ir(C_READ);
        shift_dr(32'h0, 32, data);
    endtask

    task automatic unlock();
        logic [31:0] d;
        load_ir(C_UNLOCK);
        shift_dr(32'h0, 32, d);
    endtask

    task automatic t_reset();
        logic o;
        rst = 1'b1;
        tms = 1'b1;
        repeat (3) @(posedge tck);
        @(negedge tck);
        rst = 1'b0;
        step(1'b1, 1'b0, o);
        check("R1 tdo in reset state", {31'd0, o}, 32'd0);
        step(1'b0, 1'b0, o);
        check("R11 tdo quiet in reset state", {31'd0, o}, 32'd0);
        step(1'b0, 1'b0, o);
        check("R11 tdo quiet in idle", {31'd0, o}, 32'd0);
    endtask

    task automatic t_ir_capture();
        logic [3:0] cap;
        shift_ir(C_ADDR, cap);
        check("R10 instruction capture pattern", {28'd0, cap}, 32'h1);
    endtask

    task automatic t_locked();
        logic [31:0] d;
        write_row(4'd3, 32'hDEAD_BEEF);
        read_row(4'd3, d);
        check("R7 locked read-back gives zero", d, 32'h0);
        unlock();
        read_row(4'd3, d);
        check("R7 locked write ignored, R1 erased at reset", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_program();
        logic [31:0] d;
        logic [3:0]  p;
        write_row(4'd3, 32'hDEAD_BEEF);
        write_row(4'd5, 32'h1234_5678);
        read_row(4'd3, d);
        check("R5 R6 row 3 read-back", d, 32'hDEAD_BEEF);
        set_addr(4'd5, p);
        check("R8 address capture shows previous row", {28'd0, p}, 32'd3);
        load_ir(C_READ);
        shift_dr(32'h0, 32, d);
        check("R6 row 5 read-back", d, 32'h1234_5678);
    endtask

    task automatic t_bypass();
        logic [31:0] d;
        load_ir(C_ODD);
        shift_dr(32'h0000_00B2, 8, d);
        check("R9 bypass delays tdi by one clock", d & 32'hFF, {24'd0, 8'hB2 << 1} & 32'hFF);
        read_row(4'd5, d);
        check("R3 R9 unlock survives bypass traffic", d, 32'h1234_5678);
    endtask

    task automatic t_tlr();
        logic        o;
        logic [31:0] d;
        load_ir(C_READ);
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        check("R11 R2 tdo quiet after five high clocks", {31'd0, o}, 32'd0);
        read_row(4'd3, d);
        check("R2 reset state relocked store", d, 32'h0);
        load_ir(C_CLEAR);
        idle(2);
        unlock();
        read_row(4'd3, d);
        check("R7 R2 locked clear ignored, row kept", d, 32'hDEAD_BEEF);
    endtask

    task automatic t_erase();
        logic [31:0] d;
        load_ir(C_CLEAR);
        idle(2);
        read_row(4'd3, d);
        check("R4 clear row 3", d, 32'hFFFF_FFFF);
        read_row(4'd5, d);
        check("R4 clear row 5", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_bounds();
        logic [31:0] d;
        write_row(4'd15, 32'hA5A5_0F0F);
        write_row(4'd0, 32'h0000_0001);
        read_row(4'd15, d);
        check("R8 R5 top row", d, 32'hA5A5_0F0F);
        read_row(4'd0, d);
        check("R8 R5 bottom row", d, 32'h0000_0001);
        read_row(4'd14, d);
        check("R8 neighbour row untouched", d, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (100000) @(posedge tck);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_ir_capture();
        t_locked();
        t_program();
        t_bypass();
        t_tlr();
        t_erase();
        t_bounds();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule